// File: doc/BRIEF.md
# RTC Power-Fail Flag Controller

This block watches the two supply-present signals of a real-time clock, main and backup. It records when both have been lost at once. After such a total loss it does three things: it raises a power-fail flag in a status byte, it pulses a request for the time registers to reload their defaults, and it stops the 1 Hz tick from reaching the time-keeping counters. Losing only one supply has no effect.

Counting stays frozen until software writes any single byte into the clock register window. That write also clears the flag. Writes that fall outside the window, including writes to the status byte itself, leave the flag and the frozen clock alone. The status byte also holds a few bits that software can write. Bit 0 carries the flag, and bits 3 and 4 always read as zero.

A four-state machine does the sequencing. The states are `ST_RUN`, `ST_DEAD`, `ST_LOAD` and `ST_HALT`. Its transitions are:
- RUN→DEAD when both supplies are low.
- DEAD→LOAD when either supply returns.
- LOAD→HALT after one cycle, or LOAD→DEAD if both supplies are low again.
- HALT→RUN on a clock-window write.
- HALT→DEAD when both supplies are low.

Reset is treated as a cold start and enters `ST_DEAD`.

Top module: `rtc_pwrfail_ctrl`

## Requirements
- R1: A clock edge that samples both `main_ok` and `bkup_ok` low sets status bit 0 (the flag) and drives `run_en_o` low from the next cycle. This holds in any state.
- R2: When only one supply is low, the flag, `run_en_o` and `defaults_o` stay unchanged.
- R3: After a total loss, `defaults_o` is high for exactly one cycle. That cycle directly follows the edge at which the first supply returns, whichever of the two supplies returns first.
- R4: While the flag is set, `tick_o` is 0. While running, `tick_o` equals `tick_1hz` in the same cycle.
- R5: After the reload pulse, one write (`wr_en`=1) to an address in [CLK_BASE, CLK_BASE+CLK_SPAN-1] clears the flag and raises `run_en_o` from the next cycle.
- R6: A clock-window write in the cycle of the reload pulse is ignored: the flag stays 1 and `run_en_o` stays 0.
- R7: A write to any address outside the clock window never clears the flag and never raises `run_en_o`.
- R8: Status byte layout: bit 0 is the flag and cannot be written. Bits 3 and 4 always read 0. Bits 7:5 and 2:1 hold the data of the last write to STAT_ADDR (reset value 0).
- R9: Reset leaves the flag at 1, `run_en_o` at 0 and the writable status bits at 0. With a supply present, `defaults_o` then pulses in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (cold start) |
| main_ok | input | 1 | Main supply present |
| bkup_ok | input | 1 | Backup supply present |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| tick_1hz | input | 1 | One-second tick from the divider |
| status_o | output | 8 | Status byte (bit 0 = power-fail flag) |
| run_en_o | output | 1 | Clock counting enabled |
| tick_o | output | 1 | Tick gated by the run enable |
| defaults_o | output | 1 | One-cycle request to reload time-register defaults |

## Verification
The machine's state can be read at the ports within one cycle of any transition:
- A lost or spurious DEAD entry shows as a wrong flag and run enable on the next cycle.
- A missed or doubled LOAD shows as a missing or two-cycle `defaults_o` pulse.
- A wrongly decoded clock window appears as a flag that clears on a foreign address, or that stays set on a valid one.

The bench sweeps every write address after a total loss, every supply combination from the running state, and every status data byte. The bench predicts each result arithmetically from the window bounds and the bit layout.

// File: rtl/rtc_pf_pkg.sv
package rtc_pf_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_DEAD = 2'd1,
        ST_LOAD = 2'd2,
        ST_HALT = 2'd3
    } pf_state_e;

    localparam int unsigned STAT_W = 8;
    // bits software may store; bit 0 is the flag, bits 3/4 unused
    localparam logic [STAT_W-1:0] SW_MASK = 8'b1110_0110;
endpackage

// File: rtl/rtc_pf_addr_dec.sv
module rtc_pf_addr_dec #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned CLK_BASE  = 8'h30,
    parameter int unsigned CLK_SPAN  = 8,
    parameter int unsigned STAT_ADDR = 8'h3F
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              clk_wr,
    output logic              stat_wr
);
    localparam int unsigned CLK_LAST = CLK_BASE + CLK_SPAN - 1;

    logic in_window;

    always_comb begin
        in_window = (int'(wr_addr) >= int'(CLK_BASE)) &&
                    (int'(wr_addr) <= int'(CLK_LAST));
        clk_wr    = wr_en && in_window;
        stat_wr   = wr_en && (int'(wr_addr) == int'(STAT_ADDR));
    end
endmodule

// File: rtl/rtc_pf_fsm.sv
module rtc_pf_fsm
    import rtc_pf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic main_ok,
    input  logic bkup_ok,
    input  logic clk_wr,
    output logic flag,
    output logic run_en,
    output logic defaults
);
    pf_state_e state_q;
    pf_state_e state_d;
    logic      both_lost;

    assign both_lost = !main_ok && !bkup_ok;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (both_lost) state_d = ST_DEAD;
            ST_DEAD: if (!both_lost) state_d = ST_LOAD;
            ST_LOAD: state_d = both_lost ? ST_DEAD : ST_HALT;
            ST_HALT: begin
                if (both_lost)   state_d = ST_DEAD;
                else if (clk_wr) state_d = ST_RUN;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DEAD;
        else        state_q <= state_d;
    end

    // latched total-failure flag: only the clearing write resets it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag <= 1'b1;
        else if (state_d == ST_DEAD)
            flag <= 1'b1;
        else if (state_q == ST_HALT && state_d == ST_RUN)
            flag <= 1'b0;
    end

    // state-decoded outputs
    always_comb begin
        run_en   = 1'b0;
        defaults = 1'b0;
        unique case (state_q)
            ST_RUN:  run_en   = 1'b1;
            ST_DEAD: ;
            ST_LOAD: defaults = 1'b1;
            ST_HALT: ;
        endcase
    end
endmodule

// File: rtl/rtc_pf_status.sv
module rtc_pf_status
    import rtc_pf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] wr_data,
    input  logic              flag,
    output logic [STAT_W-1:0] status
);
    logic [STAT_W-1:0] sw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sw_q <= '0;
        else if (stat_wr) sw_q <= wr_data & SW_MASK;
    end

    always_comb begin
        status    = sw_q & SW_MASK;
        status[0] = flag;
    end
endmodule

// File: rtl/rtc_pwrfail_ctrl.sv
module rtc_pwrfail_ctrl
    import rtc_pf_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned CLK_BASE  = 8'h30,
    parameter int unsigned CLK_SPAN  = 8,
    parameter int unsigned STAT_ADDR = 8'h3F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_ok,
    input  logic              bkup_ok,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              tick_1hz,
    output logic [7:0]        status_o,
    output logic              run_en_o,
    output logic              tick_o,
    output logic              defaults_o
);
    logic clk_wr;
    logic stat_wr;
    logic flag;

    rtc_pf_addr_dec #(
        .ADDR_W   (ADDR_W),
        .CLK_BASE (CLK_BASE),
        .CLK_SPAN (CLK_SPAN),
        .STAT_ADDR(STAT_ADDR)
    ) u_dec (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .clk_wr (clk_wr),
        .stat_wr(stat_wr)
    );

    rtc_pf_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .main_ok (main_ok),
        .bkup_ok (bkup_ok),
        .clk_wr  (clk_wr),
        .flag    (flag),
        .run_en  (run_en_o),
        .defaults(defaults_o)
    );

    rtc_pf_status u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_wr(stat_wr),
        .wr_data(wr_data),
        .flag   (flag),
        .status (status_o)
    );

    assign tick_o = tick_1hz && run_en_o;
endmodule

// File: rtl/rtc_pwrfail_ctrl_chk.sv
module rtc_pwrfail_ctrl_chk #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned CLK_BASE  = 8'h30,
    parameter int unsigned CLK_SPAN  = 8,
    parameter int unsigned STAT_ADDR = 8'h3F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              main_ok,
    input logic              bkup_ok,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              tick_1hz,
    input logic [7:0]        status_o,
    input logic              run_en_o,
    input logic              tick_o,
    input logic              defaults_o
);
    logic win_hit;
    logic stat_hit;

    always_comb begin
        win_hit  = wr_en && (int'(wr_addr) >= int'(CLK_BASE)) &&
                   (int'(wr_addr) < int'(CLK_BASE + CLK_SPAN));
        stat_hit = wr_en && (int'(wr_addr) == int'(STAT_ADDR));
    end

    AST_TOTAL_LOSS_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_ok && !bkup_ok) |=> (status_o[0] && !run_en_o)); // R1

    AST_FLAG_RISE_NEEDS_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[0]) |-> $past(!main_ok && !bkup_ok)); // R2

    AST_RELOAD_WHILE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        defaults_o |-> (status_o[0] && !run_en_o)); // R3

    AST_RELOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        defaults_o |=> !defaults_o); // R3

    AST_TICK_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] |-> !tick_o); // R4

    AST_RUN_NEEDS_WINDOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en_o) |-> $past(win_hit)); // R5

    AST_FLAG_CLEAR_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[0]) |-> $past(win_hit)); // R7

    AST_STATUS_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
        stat_hit |=> (status_o[4:3] == 2'b00 &&
                      status_o[7:5] == $past(wr_data[7:5]) &&
                      status_o[2:1] == $past(wr_data[2:1]))); // R8
endmodule

bind rtc_pwrfail_ctrl rtc_pwrfail_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .CLK_BASE (CLK_BASE),
    .CLK_SPAN (CLK_SPAN),
    .STAT_ADDR(STAT_ADDR)
) u_chk (.*);

// File: tb/rtc_pwrfail_ctrl_tb_top.sv
`timescale 1ns/1ps
module rtc_pwrfail_ctrl_tb_top;
    localparam int ADDR_W    = 8;
    localparam int CLK_BASE  = 8'h30;
    localparam int CLK_SPAN  = 8;
    localparam int STAT_ADDR = 8'h3F;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              main_ok = 1'b1;
    logic              bkup_ok = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              tick_1hz = 1'b0;
    logic [7:0]        status_o;
    logic              run_en_o;
    logic              tick_o;
    logic              defaults_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rtc_pwrfail_ctrl #(
        .ADDR_W(ADDR_W), .CLK_BASE(CLK_BASE),
        .CLK_SPAN(CLK_SPAN), .STAT_ADDR(STAT_ADDR)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .main_ok(main_ok), .bkup_ok(bkup_ok),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tick_1hz(tick_1hz), .status_o(status_o), .run_en_o(run_en_o),
        .tick_o(tick_o), .defaults_o(defaults_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // total loss then return of one supply; ends in the reload cycle
    task automatic lose_all(input bit main_first);
        main_ok = 1'b0; bkup_ok = 1'b0;
        step();
        chk("R1 flag", status_o[0], 1);
        chk("R1 run", run_en_o, 0);
        if (main_first) main_ok = 1'b1; else bkup_ok = 1'b1;
        step();
        chk("R3 reload", defaults_o, 1);
    endtask

    task automatic do_write(input int a, input int d);
        wr_en = 1'b1; wr_addr = a[ADDR_W-1:0]; wr_data = d[7:0];
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        // R9 reset state
        chk("R9 flag", status_o[0], 1);
        chk("R9 run", run_en_o, 0);
        chk("R9 sw bits", status_o, 8'h01);
        rst_n = 1'b1;
        step();
        chk("R9 reload after reset", defaults_o, 1);
        step();
        chk("R3 single pulse", defaults_o, 0);
        chk("R9 still halted", run_en_o, 0);

        // R4 tick masked while halted
        tick_1hz = 1'b1; #1;
        chk("R4 tick masked", tick_o, 0);
        tick_1hz = 1'b0;

        // sweep every address after a total loss, alternating which supply returns
        for (int a = 0; a < (1 << ADDR_W); a++) begin
            bit in_win;
            in_win = (a >= CLK_BASE) && (a < CLK_BASE + CLK_SPAN);
            lose_all(a[0]);
            step();
            chk("R3 one-cycle reload", defaults_o, 0);
            main_ok = 1'b1; bkup_ok = 1'b1;
            do_write(a, 8'h00);
            if (in_win) begin
                chk("R5 flag cleared", status_o[0], 0);
                chk("R5 run", run_en_o, 1);
            end else begin
                chk("R7 flag kept", status_o[0], 1);
                chk("R7 run kept off", run_en_o, 0);
            end
        end

        // R6 window write during the reload cycle is ignored
        lose_all(1'b0);
        do_write(CLK_BASE, 0);
        chk("R6 flag kept", status_o[0], 1);
        chk("R6 run off", run_en_o, 0);
        do_write(CLK_BASE + CLK_SPAN - 1, 0);
        chk("R5 top of window clears", status_o[0], 0);

        // R4 tick passes while running
        tick_1hz = 1'b1; #1;
        chk("R4 tick passes", tick_o, 1);
        tick_1hz = 1'b0; #1;
        chk("R4 tick low", tick_o, 0);

        // R2: all single-supply combinations from running
        for (int c = 1; c < 4; c++) begin
            main_ok = c[0]; bkup_ok = c[1];
            step(); step();
            chk("R2 flag", status_o[0], 0);
            chk("R2 run", run_en_o, 1);
            chk("R2 no reload", defaults_o, 0);
        end
        main_ok = 1'b1; bkup_ok = 1'b1;

        // R8 exhaustive status data sweep
        for (int d = 0; d < 256; d++) begin
            do_write(STAT_ADDR, d);
            chk("R8 status", status_o, d & 8'hE6);
        end
        chk("R8 running after status writes", run_en_o, 1);

        // R1 from halted: loss during halt keeps flag
        lose_all(1'b1);
        step();
        main_ok = 1'b0; bkup_ok = 1'b0;
        step();
        chk("R1 loss while halted", status_o[0], 1);
        main_ok = 1'b1;
        step();
        chk("R3 reload again", defaults_o, 1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule